// File: doc/BRIEF.md
# Logic Self-Test Sequencing Controller

This block drives a scan-based logic self test in which a pseudo-random pattern generator fills the scan chains and a multiple-input signature register compacts what comes out of them. Only the controller is built here: a state machine and three counters. The generator, the register and the chains sit outside it and follow its enables.

A rising edge on the start input while the controller is idle launches a test. The controller first loads the configuration, which is the longest chain length, the pattern count and the capture cycles per pattern, and then spends one cycle seeding. It then repeats two phases once per pattern: a shift phase, during which the generator advances and the signature register compacts, and a capture phase, during which only the capture clock runs. After the last capture, one extra shift phase moves the final responses into the signature register. A single compare strobe follows, and the controller then raises done. Done stays high until the start input is released.

Top module: `lbist_seq_ctrl`

## Requirements
- R1: While reset is asserted, and afterwards until a start is accepted, every control output, busy and done are low.
- R2: A rising edge of `start_i` while the controller is idle is accepted. In the following cycle busy is high and `seed_ld_o` is high for exactly one cycle. No scan enable comes before that seed cycle.
- R3: In every shift phase, `scan_en_o`, `shift_clk_en_o`, `prpg_en_o` and `misr_en_o` are high together for exactly L consecutive cycles, where L is the latched chain length.
- R4: In every capture phase, `cap_clk_en_o` is high for exactly C consecutive cycles. During those cycles scan enable, the shift clock, the generator and the signature register are all disabled.
- R5: A test of P patterns has P shift phases, each followed by a capture phase, then one final shift phase. Scan enable is therefore high for (P+1)*L cycles in total and the capture clock for P*C cycles.
- R6: `sig_cmp_o` is high for exactly one cycle, right after the final shift phase. Done rises in the next cycle, and busy is high for exactly 2 + P*(L+C) + L cycles.
- R7: Done stays high for as long as `start_i` stays high. One cycle after `start_i` goes low, done and busy are both low and the controller is idle.
- R8: A start edge that arrives while busy has no effect on the sequence.
- R9: The configuration is latched when a start is accepted, so later changes to the configuration inputs have no effect on the running test. A programmed value of zero for L, P or C acts as one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Test launch request (rising edge), held to keep done |
| chain_len_i | input | LEN_W | Longest scan-chain length L |
| pat_num_i | input | PAT_W | Number of patterns P |
| cap_num_i | input | CAP_W | Capture cycles per pattern C |
| scan_en_o | output | 1 | Scan enable |
| shift_clk_en_o | output | 1 | Shift clock gate enable |
| cap_clk_en_o | output | 1 | Capture clock gate enable |
| prpg_en_o | output | 1 | Pattern generator advance enable |
| misr_en_o | output | 1 | Signature register compaction enable |
| seed_ld_o | output | 1 | Seed load strobe |
| sig_cmp_o | output | 1 | Signature compare strobe |
| busy_o | output | 1 | Test in progress |
| done_o | output | 1 | Test finished |

## Verification
The bench measures the length of every scan-enable run and every capture run. An off-by-one in the shift or capture counter would show up as runs one cycle too long or too short, and a design that skips the final unload shift would come up L scan cycles short. One test sets L, P and C all to one, and another sets them all to zero. A design that did not clamp zero would wrap its counters and run for tens of thousands of cycles. A start pulse and a change of configuration in the middle of a test must leave every count unchanged, which exposes a design that restarts or reads its configuration inputs live. Done must stay high while start is held, and it must clear one cycle after start is released.

// File: rtl/lbist_pkg.sv
package lbist_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_SEED    = 3'd1,
        ST_SHIFT   = 3'd2,
        ST_CAPTURE = 3'd3,
        ST_FINAL   = 3'd4,
        ST_COMPARE = 3'd5,
        ST_DONE    = 3'd6
    } seq_state_e;

    typedef struct packed {
        logic scan_en;
        logic shift_clk_en;
        logic cap_clk_en;
        logic prpg_en;
        logic misr_en;
        logic seed_ld;
        logic sig_cmp;
        logic busy;
        logic done;
    } ctl_t;

    function automatic ctl_t decode_ctl(seq_state_e s);
        ctl_t c;
        c = '0;
        case (s)
            ST_SEED: begin
                c.seed_ld = 1'b1;
                c.busy    = 1'b1;
            end
            ST_SHIFT, ST_FINAL: begin
                c.scan_en      = 1'b1;
                c.shift_clk_en = 1'b1;
                c.prpg_en      = 1'b1;
                c.misr_en      = 1'b1;
                c.busy         = 1'b1;
            end
            ST_CAPTURE: begin
                c.cap_clk_en = 1'b1;
                c.busy       = 1'b1;
            end
            ST_COMPARE: begin
                c.sig_cmp = 1'b1;
                c.busy    = 1'b1;
            end
            ST_DONE: c.done = 1'b1;
            default: c = '0;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/lbist_cnt.sv
module lbist_cnt #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic         last_o
);
    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= (load_val == '0) ? ONE : load_val;
        end else if (dec && cnt != '0) begin
            cnt <= cnt - ONE;
        end
    end

    assign last_o = (cnt == ONE);
endmodule

// File: rtl/lbist_fsm.sv
module lbist_fsm
    import lbist_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start_lvl,
    input  logic       start_rise,
    input  logic       sh_last,
    input  logic       cap_last,
    input  logic       pat_last,
    output seq_state_e state_o,
    output logic       accept_o,
    output logic       sh_load_o,
    output logic       sh_dec_o,
    output logic       cap_load_o,
    output logic       cap_dec_o,
    output logic       pat_load_o,
    output logic       pat_dec_o
);
    seq_state_e state, nxt;

    always_comb begin
        nxt = state;
        case (state)
            ST_IDLE:    if (start_rise) nxt = ST_SEED;
            ST_SEED:    nxt = ST_SHIFT;
            ST_SHIFT:   if (sh_last) nxt = ST_CAPTURE;
            ST_CAPTURE: if (cap_last) nxt = pat_last ? ST_FINAL : ST_SHIFT;
            ST_FINAL:   if (sh_last) nxt = ST_COMPARE;
            ST_COMPARE: nxt = ST_DONE;
            ST_DONE:    if (!start_lvl) nxt = ST_IDLE;
            default:    nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= nxt;
    end

    assign state_o    = state;
    assign accept_o   = (state == ST_IDLE) && start_rise;
    assign sh_load_o  = (state == ST_SEED) || (state == ST_CAPTURE && cap_last);
    assign sh_dec_o   = (state == ST_SHIFT) || (state == ST_FINAL);
    assign cap_load_o = (state == ST_SHIFT) && sh_last;
    assign cap_dec_o  = (state == ST_CAPTURE);
    assign pat_load_o = (state == ST_SEED);
    assign pat_dec_o  = (state == ST_CAPTURE) && cap_last;
endmodule

// File: rtl/lbist_seq_ctrl.sv
module lbist_seq_ctrl
    import lbist_pkg::*;
#(
    parameter int LEN_W = 16,
    parameter int PAT_W = 20,
    parameter int CAP_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [LEN_W-1:0] chain_len_i,
    input  logic [PAT_W-1:0] pat_num_i,
    input  logic [CAP_W-1:0] cap_num_i,
    output logic             scan_en_o,
    output logic             shift_clk_en_o,
    output logic             cap_clk_en_o,
    output logic             prpg_en_o,
    output logic             misr_en_o,
    output logic             seed_ld_o,
    output logic             sig_cmp_o,
    output logic             busy_o,
    output logic             done_o
);
    logic             start_q;
    logic             start_rise;
    logic [LEN_W-1:0] len_q;
    logic [PAT_W-1:0] pat_q;
    logic [CAP_W-1:0] cap_q;
    seq_state_e       state;
    logic             accept;
    logic             sh_load, sh_dec, sh_last;
    logic             cap_load, cap_dec, cap_last;
    logic             pat_load, pat_dec, pat_last;
    ctl_t             ctl;

    always_ff @(posedge clk) begin
        if (rst) start_q <= 1'b0;
        else     start_q <= start_i;
    end
    assign start_rise = start_i && !start_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            len_q <= '0;
            pat_q <= '0;
            cap_q <= '0;
        end else if (accept) begin
            len_q <= chain_len_i;
            pat_q <= pat_num_i;
            cap_q <= cap_num_i;
        end
    end

    lbist_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .start_lvl  (start_i),
        .start_rise (start_rise),
        .sh_last    (sh_last),
        .cap_last   (cap_last),
        .pat_last   (pat_last),
        .state_o    (state),
        .accept_o   (accept),
        .sh_load_o  (sh_load),
        .sh_dec_o   (sh_dec),
        .cap_load_o (cap_load),
        .cap_dec_o  (cap_dec),
        .pat_load_o (pat_load),
        .pat_dec_o  (pat_dec)
    );

    lbist_cnt #(.W(LEN_W)) u_shift_cnt (
        .clk(clk), .rst(rst), .load(sh_load), .load_val(len_q),
        .dec(sh_dec), .last_o(sh_last)
    );

    lbist_cnt #(.W(CAP_W)) u_cap_cnt (
        .clk(clk), .rst(rst), .load(cap_load), .load_val(cap_q),
        .dec(cap_dec), .last_o(cap_last)
    );

    lbist_cnt #(.W(PAT_W)) u_pat_cnt (
        .clk(clk), .rst(rst), .load(pat_load), .load_val(pat_q),
        .dec(pat_dec), .last_o(pat_last)
    );

    assign ctl            = decode_ctl(state);
    assign scan_en_o      = ctl.scan_en;
    assign shift_clk_en_o = ctl.shift_clk_en;
    assign cap_clk_en_o   = ctl.cap_clk_en;
    assign prpg_en_o      = ctl.prpg_en;
    assign misr_en_o      = ctl.misr_en;
    assign seed_ld_o      = ctl.seed_ld;
    assign sig_cmp_o      = ctl.sig_cmp;
    assign busy_o         = ctl.busy;
    assign done_o         = ctl.done;
endmodule

// File: rtl/lbist_seq_chk.sv
module lbist_seq_chk (
    input logic clk,
    input logic rst,
    input logic start_i,
    input logic scan_en_o,
    input logic shift_clk_en_o,
    input logic cap_clk_en_o,
    input logic prpg_en_o,
    input logic misr_en_o,
    input logic seed_ld_o,
    input logic sig_cmp_o,
    input logic busy_o,
    input logic done_o
);
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> !scan_en_o && !cap_clk_en_o && !seed_ld_o && !sig_cmp_o); // R1

    AST_BUSY_SEEDS: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_o) |-> seed_ld_o); // R2

    AST_SHIFT_GROUP: assert property (@(posedge clk) disable iff (rst)
        scan_en_o |-> shift_clk_en_o && prpg_en_o && misr_en_o); // R3

    AST_CAP_EXCL: assert property (@(posedge clk) disable iff (rst)
        cap_clk_en_o |-> !scan_en_o && !misr_en_o && !prpg_en_o && !shift_clk_en_o); // R4

    AST_CMP_TO_DONE: assert property (@(posedge clk) disable iff (rst)
        sig_cmp_o |=> done_o && !sig_cmp_o); // R6

    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
        !(done_o && busy_o)); // R6

    AST_DONE_HOLD: assert property (@(posedge clk) disable iff (rst)
        done_o && start_i |=> done_o); // R7

    AST_DONE_RELEASE: assert property (@(posedge clk) disable iff (rst)
        done_o && !start_i |=> !done_o && !busy_o); // R7
endmodule

bind lbist_seq_ctrl lbist_seq_chk u_chk (.*);

// File: tb/lbist_seq_ctrl_tb.sv
module lbist_seq_ctrl_tb;
    localparam int LEN_W = 16;
    localparam int PAT_W = 20;
    localparam int CAP_W = 4;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             start_i = 1'b0;
    logic [LEN_W-1:0] chain_len_i = '0;
    logic [PAT_W-1:0] pat_num_i = '0;
    logic [CAP_W-1:0] cap_num_i = '0;
    logic scan_en_o, shift_clk_en_o, cap_clk_en_o, prpg_en_o, misr_en_o;
    logic seed_ld_o, sig_cmp_o, busy_o, done_o;

    int n_checks = 0;
    int n_fail   = 0;

    always #2.5 clk = ~clk;

    lbist_seq_ctrl #(.LEN_W(LEN_W), .PAT_W(PAT_W), .CAP_W(CAP_W)) u_dut (
        .clk(clk), .rst(rst), .start_i(start_i),
        .chain_len_i(chain_len_i), .pat_num_i(pat_num_i), .cap_num_i(cap_num_i),
        .scan_en_o(scan_en_o), .shift_clk_en_o(shift_clk_en_o),
        .cap_clk_en_o(cap_clk_en_o), .prpg_en_o(prpg_en_o), .misr_en_o(misr_en_o),
        .seed_ld_o(seed_ld_o), .sig_cmp_o(sig_cmp_o), .busy_o(busy_o), .done_o(done_o)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        check({scan_en_o, shift_clk_en_o, cap_clk_en_o, prpg_en_o, misr_en_o,
               seed_ld_o, sig_cmp_o, busy_o, done_o} == '0,
              "R1", "outputs during reset", int'(busy_o | done_o | scan_en_o), 0);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        check({scan_en_o, cap_clk_en_o, seed_ld_o, busy_o, done_o} == '0,
              "R1", "outputs idle after reset", int'(busy_o | done_o), 0);
    endtask

    // Runs one test; disturb=1 pulses start and changes configuration mid-run (R8, R9).
    task automatic run_test(input int l, input int p, input int c, input bit disturb,
                            input bit hold_done);
        int le, pe, ce;
        int busy_c = 0, scan_c = 0, cap_c = 0, seed_c = 0, cmp_c = 0;
        int sh_run = 0, cap_run = 0, bad_sh = 0, bad_cap = 0, sh_runs = 0, cap_runs = 0;
        int grp_bad = 0, cyc = 0;
        bit seed_late = 0, first_ok, last_cmp = 0, timeout = 0;
        le = (l == 0) ? 1 : l;
        pe = (p == 0) ? 1 : p;
        ce = (c == 0) ? 1 : c;
        @(negedge clk);
        chain_len_i = LEN_W'(l);
        pat_num_i   = PAT_W'(p);
        cap_num_i   = CAP_W'(c);
        start_i     = 1'b1;
        @(negedge clk);
        first_ok = busy_o && seed_ld_o && !scan_en_o;
        check(first_ok, "R2", "busy and seed one cycle after start", int'(first_ok), 1);
        while (!done_o) begin
            if (cyc > 20000) begin timeout = 1; break; end
            busy_c += int'(busy_o);
            scan_c += int'(scan_en_o);
            cap_c  += int'(cap_clk_en_o);
            seed_c += int'(seed_ld_o);
            cmp_c  += int'(sig_cmp_o);
            if (seed_ld_o && scan_c > 0) seed_late = 1;
            if (scan_en_o != prpg_en_o || scan_en_o != misr_en_o || scan_en_o != shift_clk_en_o)
                grp_bad++;
            if (cap_clk_en_o && (misr_en_o || prpg_en_o || scan_en_o || shift_clk_en_o))
                grp_bad++;
            if (scan_en_o) sh_run++;
            else if (sh_run > 0) begin
                sh_runs++; if (sh_run != le) bad_sh++; sh_run = 0;
            end
            if (cap_clk_en_o) cap_run++;
            else if (cap_run > 0) begin
                cap_runs++; if (cap_run != ce) bad_cap++; cap_run = 0;
            end
            last_cmp = sig_cmp_o;
            if (disturb) begin
                if (cyc == 2) start_i = 1'b0;
                if (cyc == 4) begin
                    chain_len_i = LEN_W'(l + 7);
                    pat_num_i   = PAT_W'(p + 2);
                    cap_num_i   = CAP_W'(c + 1);
                end
                if (cyc == 6) start_i = 1'b1;
                if (cyc == 7) start_i = 1'b0;
            end
            cyc++;
            @(negedge clk);
        end
        check(!timeout, "R6", "test reached done", int'(timeout), 0);
        check(busy_c == 2 + pe * (le + ce) + le, "R6", "busy cycles", busy_c,
              2 + pe * (le + ce) + le);
        check(scan_c == (pe + 1) * le, "R5", "scan enable cycles", scan_c, (pe + 1) * le);
        check(sh_runs == pe + 1 && bad_sh == 0, "R3", "shift phases of length L",
              sh_runs * 1000 + bad_sh, (pe + 1) * 1000);
        check(cap_c == pe * ce && cap_runs == pe && bad_cap == 0, "R4",
              "capture cycles", cap_c, pe * ce);
        check(grp_bad == 0, "R4", "enable grouping violations", grp_bad, 0);
        check(seed_c == 1 && !seed_late, "R2", "single early seed", seed_c, 1);
        check(cmp_c == 1 && last_cmp, "R6", "compare strobe before done", cmp_c, 1);
        if (disturb)
            check(busy_c == 2 + pe * (le + ce) + le, "R9", "config change and R8 start pulse ignored",
                  busy_c, 2 + pe * (le + ce) + le);
        if (hold_done) begin
            repeat (3) @(negedge clk);
            check(done_o && !busy_o, "R7", "done held while start high", int'(done_o), 1);
        end
        start_i = 1'b0;
        @(negedge clk);
        check(!done_o && !busy_o, "R7", "done clears after start low", int'(done_o), 0);
        repeat (2) @(negedge clk);
        check(!busy_o && !scan_en_o && !cap_clk_en_o, "R1", "idle between tests",
              int'(busy_o), 0);
    endtask

    task automatic t_basic();      run_test(5, 3, 1, 1'b0, 1'b1); endtask
    task automatic t_multi_cap();  run_test(8, 2, 3, 1'b0, 1'b1); endtask
    task automatic t_minimal();    run_test(1, 1, 1, 1'b0, 1'b1); endtask
    task automatic t_zero_cfg();   run_test(0, 0, 0, 1'b0, 1'b0); endtask // R9 clamp
    task automatic t_disturbed();  run_test(3, 4, 2, 1'b1, 1'b0); endtask // R8 R9

    initial begin
        repeat (2) @(negedge clk);
        t_reset();
        t_basic();
        t_multi_cap();
        t_minimal();
        t_zero_cfg();
        t_disturbed();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #500000;
        n_checks++;
        n_fail++;
        $display("FAIL R6 watchdog expired: actual 1 expected 0");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule